// File: doc/BRIEF.md
# Inter-VM Doorbell Register Block

This block is the register face of a shared-memory doorbell device. It answers 32-bit register reads and writes, and it holds an interrupt mask word, an interrupt status word that clears when read, and a read-only word giving this node's own position. A write to the doorbell word sends a notification to another peer. The written word carries the target peer and a vector number. Both are checked against a table of per-peer vector counts, and a request that fails either check is dropped without a trace.

Events arrive on the block's own vectors as one-cycle strobes. They are delivered in one of two modes. In legacy mode any event writes the value 1 into the status word. In message mode each event becomes a one-cycle pulse on its own vector, provided message delivery is globally enabled. If the vector is masked at that moment, the event is parked as a pending bit instead. It is delivered exactly once when the vector is next unmasked while delivery is enabled.

The per-peer vector counts are loaded through a small configuration port. Loading an entry for peer p also makes peers 0..p known to the doorbell check.

Top module: `doorbell_regs`

## Requirements
- R1: After reset, the mask word, status word, pending bits, message pulses and doorbell strobe are all zero, and no peer is known.
- R2: Offset 0x00 holds a 32-bit read/write mask word, which reads back exactly as written.
- R3: A read of offset 0x04 returns the status word in `rd_data` one cycle after the read strobe, and the status word is zero afterwards. A write to 0x04 loads it.
- R4: Offset 0x08 reads `own_id` zero-extended, and writes to it have no effect. Offset 0x0C and every unmapped offset read as zero, and writes to unmapped offsets change nothing.
- R5: On writes, address bits 1:0 are ignored (0x02 writes the mask, 0x0F rings the doorbell). Reads decode the full address, so 0x01 reads zero.
- R6: A doorbell write takes the destination from bits 31:16 and the vector from bits 7:0, and ignores bits 15:8. When accepted, `db_valid` is high for exactly the one cycle after the write, with `db_dest` and `db_vec` holding those fields.
- R7: A doorbell write whose destination is greater than or equal to the number of known peers produces no strobe.
- R8: A doorbell write whose vector is greater than or equal to the destination peer's loaded vector count produces no strobe. A count of zero blocks every vector.
- R9: A configuration write stores the count for `cfg_peer`, and raises the number of known peers to `cfg_peer`+1 when that is larger.
- R10: In legacy mode (`msg_mode`=0), a cycle with any `evt_in` bit set writes 1 into the status word, and no message pulse is produced.
- R11: In message mode, an event on an unmasked vector gives a one-cycle `msg_pulse` bit on that vector in the next cycle when `msg_en` is 1. When `msg_en` is 0, the event is dropped.
- R12: In message mode, an event on a masked vector sets its `pend` bit and produces no pulse. When the vector is unmasked with `msg_en` high, one pulse is produced in the next cycle and the `pend` bit clears.
- R13: If a legacy event lands in the same cycle as a status read, the read returns the old value and the status word ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| own_id | input | 16 | This node's position, shown at offset 0x08 |
| cfg_we | input | 1 | Per-peer count table write strobe |
| cfg_peer | input | 4 | Peer index for the table write |
| cfg_cnt | input | 9 | Vector count for that peer |
| db_valid | output | 1 | One-cycle doorbell strobe |
| db_dest | output | 16 | Destination peer of the doorbell |
| db_vec | output | 8 | Vector of the doorbell |
| msg_mode | input | 1 | 1 = message delivery, 0 = legacy status delivery |
| msg_en | input | 1 | Global message delivery enable |
| vec_mask | input | 4 | Per-vector mask for message delivery |
| evt_in | input | 4 | Incoming event strobes on own vectors |
| msg_pulse | output | 4 | Per-vector message pulses |
| pend | output | 4 | Per-vector pending bits |

## Verification
A status read and a legacy event can fall in the same cycle. The ordering of those two decides whether an interrupt is lost. The bench first loads the status word with a known pattern, then raises an event strobe together with the read strobe. It judges the result by requiring the old pattern on the read and 1 on a second read. A pending-vector release and a fresh event on that same vector can also meet. The bench confirms that unmasking yields a single pulse and a cleared pending bit.

// File: rtl/doorbell_regs.sv
module doorbell_regs #(
  parameter int NUM_PEERS = 16,
  parameter int NUM_VEC   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [7:0]         addr,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic [15:0]        own_id,
  input  logic               cfg_we,
  input  logic [$clog2(NUM_PEERS)-1:0] cfg_peer,
  input  logic [8:0]         cfg_cnt,
  output logic               db_valid,
  output logic [15:0]        db_dest,
  output logic [7:0]         db_vec,
  input  logic               msg_mode,
  input  logic               msg_en,
  input  logic [NUM_VEC-1:0] vec_mask,
  input  logic [NUM_VEC-1:0] evt_in,
  output logic [NUM_VEC-1:0] msg_pulse,
  output logic [NUM_VEC-1:0] pend
);
  localparam int IDX_W = $clog2(NUM_PEERS);
  localparam int KN_W  = IDX_W + 1;

  logic [31:0]      mask_q, stat_q;
  logic [8:0]       cnt_tab [NUM_PEERS];
  logic [KN_W-1:0]  known_q;

  wire [5:0]  wsel   = addr[7:2];
  wire        wr_msk = wr_en && wsel == 6'd0;
  wire        wr_st  = wr_en && wsel == 6'd1;
  wire        wr_db  = wr_en && wsel == 6'd3;
  wire        rd_st  = rd_en && addr == 8'h04;
  wire        lg_evt = !msg_mode && |evt_in;

  wire [15:0]      req_dest = wr_data[31:16];
  wire [7:0]       req_vec  = wr_data[7:0];
  wire             dest_ok  = {16'd0, req_dest} < {{(32-KN_W){1'b0}}, known_q};
  wire [IDX_W-1:0] dest_idx = req_dest[IDX_W-1:0];
  wire             vec_ok   = {1'b0, req_vec} < cnt_tab[dest_idx];
  wire [KN_W-1:0]  cfg_need = {1'b0, cfg_peer} + 1'b1;

  wire [NUM_VEC-1:0] live = (evt_in | pend) & ~vec_mask;
  wire [NUM_VEC-1:0] fire = (msg_mode && msg_en) ? live : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      stat_q    <= '0;
      rd_data   <= '0;
      known_q   <= '0;
      db_valid  <= 1'b0;
      db_dest   <= '0;
      db_vec    <= '0;
      msg_pulse <= '0;
      pend      <= '0;
      for (int i = 0; i < NUM_PEERS; i++) cnt_tab[i] <= '0;
    end else begin
      if (wr_msk) mask_q <= wr_data;
      if (lg_evt)     stat_q <= 32'd1;
      else if (wr_st) stat_q <= wr_data;
      else if (rd_st) stat_q <= '0;
      if (rd_en) begin
        case (addr)
          8'h00:   rd_data <= mask_q;
          8'h04:   rd_data <= stat_q;
          8'h08:   rd_data <= {16'd0, own_id};
          default: rd_data <= '0;
        endcase
      end
      if (cfg_we) begin
        cnt_tab[cfg_peer] <= cfg_cnt;
        if (cfg_need > known_q) known_q <= cfg_need;
      end
      db_valid <= wr_db && dest_ok && vec_ok;
      if (wr_db) begin
        db_dest <= req_dest;
        db_vec  <= req_vec;
      end
      msg_pulse <= fire;
      if (msg_mode) pend <= (pend | (evt_in & vec_mask)) & ~fire;
    end
  end

  // R7
  db_dest_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> ({16'd0, db_dest} < {{(32-KN_W){1'b0}}, known_q}));
  // R10
  legacy_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_mode |=> msg_pulse == '0);
  // R12
  masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (msg_pulse & $past(vec_mask)) == '0);
  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && !wr_en && !lg_evt) |=> stat_q == '0);
  // R13
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lg_evt |=> stat_q == 32'd1);
endmodule

// File: tb/tb_doorbell_regs.sv
module tb_doorbell_regs;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [15:0] own_id = 16'h0007;
  logic cfg_we = 0;
  logic [3:0] cfg_peer = 0;
  logic [8:0] cfg_cnt = 0;
  logic db_valid;
  logic [15:0] db_dest;
  logic [7:0] db_vec;
  logic msg_mode = 0, msg_en = 0;
  logic [3:0] vec_mask = 0, evt_in = 0, msg_pulse, pend;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  doorbell_regs dut (.*);

  // kind: 0 write/no strobe, 1 write/strobe {dest,vec}, 2 read
  localparam int NT = 20;
  localparam logic [73:0] TBL [NT] = '{
    {2'd0, 8'h00, 32'hA5A50F0F, 32'h0},         // R2
    {2'd2, 8'h00, 32'h0, 32'hA5A50F0F},         // R2
    {2'd0, 8'h02, 32'h12345678, 32'h0},         // R5
    {2'd2, 8'h00, 32'h0, 32'h12345678},         // R5
    {2'd2, 8'h01, 32'h0, 32'h0},                // R5
    {2'd0, 8'h08, 32'h0000FFFF, 32'h0},         // R4
    {2'd2, 8'h08, 32'h0, 32'h00000007},         // R4
    {2'd2, 8'h0C, 32'h0, 32'h0},                // R4
    {2'd2, 8'h40, 32'h0, 32'h0},                // R4
    {2'd0, 8'h40, 32'hDEADBEEF, 32'h0},         // R4
    {2'd2, 8'h00, 32'h0, 32'h12345678},         // R4
    {2'd1, 8'h0C, 32'h0000FF03, 32'h00000003},  // R6
    {2'd1, 8'h0C, 32'h00020000, 32'h00000200},  // R6
    {2'd0, 8'h0C, 32'h00020001, 32'h0},         // R8
    {2'd0, 8'h0C, 32'h00010000, 32'h0},         // R8
    {2'd0, 8'h0C, 32'h00030000, 32'h0},         // R7
    {2'd1, 8'h0F, 32'h00000001, 32'h00000001},  // R5
    {2'd0, 8'h04, 32'h00000055, 32'h0},         // R3
    {2'd2, 8'h04, 32'h0, 32'h00000055},         // R3
    {2'd2, 8'h04, 32'h0, 32'h0}                 // R3
  };

  function automatic string tag(int i);
    case (i)
      0, 1: return "R2";
      2, 3, 4, 16: return "R5";
      11, 12: return "R6";
      13, 14: return "R8";
      15: return "R7";
      17, 18, 19: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic cfg(input logic [3:0] p, input logic [8:0] c);
    @(negedge clk); cfg_we = 1; cfg_peer = p; cfg_cnt = c;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic evt(input logic [3:0] e);
    @(negedge clk); evt_in = e;
    @(negedge clk); evt_in = 0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(db_valid == 0 && msg_pulse == 0 && pend == 0, "R1", {db_valid, msg_pulse, pend}, 0);
    rd(8'h00); check(rd_data == 0, "R1", rd_data, 0);
    rd(8'h04); check(rd_data == 0, "R1", rd_data, 0);
    wr(8'h0C, 32'h0); check(db_valid == 0, "R1", db_valid, 0);

    cfg(4'd0, 9'd4); cfg(4'd2, 9'd1);

    for (int i = 0; i < NT; i++) begin
      logic [1:0] k; logic [7:0] a; logic [31:0] d, e;
      {k, a, d, e} = TBL[i];
      if (k == 2) begin
        rd(a); check(rd_data == e, tag(i), rd_data, e);
      end else begin
        @(negedge clk); wr_en = 1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
        if (k == 1)
          check(db_valid && {db_dest, db_vec} == e[23:0], tag(i), {7'd0, db_valid, db_dest, db_vec}, {8'h01, e[23:0]});
        else
          check(!db_valid, tag(i), db_valid, 0);
      end
    end

    // R6 strobe lasts one cycle
    wr(8'h0C, 32'h00000002);
    @(negedge clk); check(!db_valid, "R6", db_valid, 0);

    // R9 growing known peers
    wr(8'h0C, 32'h00050001); check(!db_valid, "R9", db_valid, 0);
    cfg(4'd5, 9'd2);
    wr(8'h0C, 32'h00050001); check(db_valid && db_dest == 5 && db_vec == 1, "R9", {db_dest, db_vec}, 32'h0501);
    wr(8'h0C, 32'h00040000); check(!db_valid, "R9", db_valid, 0);

    // R10 legacy event
    msg_mode = 0;
    wr(8'h04, 32'h0);
    evt(4'b0100);
    check(msg_pulse == 0, "R10", msg_pulse, 0);
    rd(8'h04); check(rd_data == 1, "R10", rd_data, 1);

    // R13 event and status read in the same cycle
    wr(8'h04, 32'h00000055);
    @(negedge clk); rd_en = 1; addr = 8'h04; evt_in = 4'b0001;
    @(negedge clk); rd_en = 0; evt_in = 0;
    check(rd_data == 32'h55, "R13", rd_data, 32'h55);
    rd(8'h04); check(rd_data == 1, "R13", rd_data, 1);
    rd(8'h04); check(rd_data == 0, "R13", rd_data, 0);

    // R11 message delivery
    msg_mode = 1; msg_en = 1; vec_mask = 0;
    evt(4'b0010);
    check(msg_pulse == 4'b0010, "R11", msg_pulse, 4'b0010);
    @(negedge clk); check(msg_pulse == 0, "R11", msg_pulse, 0);
    msg_en = 0;
    evt(4'b1000);
    check(msg_pulse == 0 && pend == 0, "R11", {msg_pulse, pend}, 0);
    rd(8'h04); check(rd_data == 0, "R11", rd_data, 0);

    // R12 masked vector latches, then releases once
    msg_en = 1; vec_mask = 4'b0100;
    evt(4'b0100);
    check(msg_pulse == 0 && pend == 4'b0100, "R12", {msg_pulse, pend}, 4'b0100);
    repeat (3) @(negedge clk);
    check(msg_pulse == 0 && pend == 4'b0100, "R12", {msg_pulse, pend}, 4'b0100);
    vec_mask = 0;
    @(negedge clk); check(msg_pulse == 4'b0100 && pend == 0, "R12", {msg_pulse, pend}, 8'h40);
    @(negedge clk); check(msg_pulse == 0, "R12", msg_pulse, 0);

    // R1 reset clears written state
    wr(8'h00, 32'hFFFFFFFF);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(8'h00); check(rd_data == 0, "R1", rd_data, 0);
    wr(8'h0C, 32'h0); check(!db_valid, "R1", db_valid, 0);

    summary();
  end
endmodule